// File: doc/BRIEF.md
# Indirect Register Window Bridge

This bridge gives a host that decodes only a small I/O window a path into a much larger internal register space. The window is 256 bytes wide. It holds a pointer register and a data port. The host first writes a target address into the pointer register. Each later read or write of the data port is then carried out on the internal register bus at that address. A fixed base offset is added to the address first, and the sum wraps within the 512 KB space.

The pointer is not tied to any one transaction. It keeps its value until the host writes it again, so several data-port accesses in a row all reach the same internal word. If anything rewrites the pointer between setup and the data access, the data access goes to the new address.

The internal bus uses a request/ready handshake, and a data-port access holds off the host acknowledge until the internal side answers. Every access is a 32-bit word.

Top module: `ind_window_bridge`

## Requirements
- R1: After reset, `host_ack` and `ib_req` are low, and a read of the pointer register returns 0.
- R2: The pointer register sits at byte offset 0x40 and the data port at 0x44. A write to the pointer register keeps data bits [18:2] and clears bits [1:0] and everything above bit 18. A read of the pointer register returns that stored value zero-extended to 32 bits. A pointer register access is acknowledged one cycle after the request is taken.
- R3: A write to the data port issues exactly one internal write. Its `ib_addr` is the stored pointer plus `REG_BASE`, and its `ib_wdata` is the host write data.
- R4: A read of the data port issues exactly one internal read. `host_ack` rises in the cycle after `ib_req` and `ib_ready` are both high, and `host_rdata` then holds `ib_rdata`. From request to acknowledge a data-port access takes 2 cycles plus the number of internal wait cycles.
- R5: While `ib_req` is high and `ib_ready` is low, `ib_req`, `ib_we`, `ib_addr` and `ib_wdata` hold their values.
- R6: `host_ack` is a single-cycle pulse. The host drops `host_req` in the cycle in which it sees the acknowledge.
- R7: The address used by a data-port access is the last value written to the pointer register. It stays in place across any number of data-port accesses.
- R8: Any other window offset, including an offset that is not word aligned, behaves as follows:
  - a read returns 0;
  - a write changes nothing;
  - no internal access is issued;
  - the acknowledge comes one cycle after the request.
- R9: The sum of pointer and base wraps modulo 2^19, so an address past the end of the 512 KB space lands back at its low end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 8 | Byte offset inside the window |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle access acknowledge |
| host_rdata | output | 32 | Host read data, valid with `host_ack` |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus write enable |
| ib_addr | output | 19 | Internal byte address |
| ib_wdata | output | 32 | Internal write data |
| ib_rdata | input | 32 | Internal read data |
| ib_ready | input | 1 | Internal bus completion |

## Verification
The main path is tried with pointer values chosen to exercise the address arithmetic:
- Zero shows the base offset alone.
- A value with its low two bits set shows the alignment masking.
- A value near the top of the space makes the base addition wrap.
- A value above 512 KB shows the truncation.
- An all-ones value combines truncation and masking.

Each of these is paired with reads and writes at internal wait counts from zero to four. This separates a correct stall length from an acknowledge that comes early or late. Directed cases then rewrite the pointer between setup and use, repeat data accesses without a rewrite, and touch unmapped and misaligned offsets to show they reach nothing inside.

// File: rtl/ixw_pkg.sv
package ixw_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PTR,
        SEL_PORT
    } win_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/ixw_decode.sv
module ixw_decode
    import ixw_pkg::*;
#(
    parameter int                WIN_AW   = 8,
    parameter logic [WIN_AW-1:0] PTR_OFF  = 8'h40,
    parameter logic [WIN_AW-1:0] PORT_OFF = 8'h44
) (
    input  logic [WIN_AW-1:0] win_addr,
    output win_sel_t          sel
);

    always_comb begin
        sel = SEL_NONE;
        if (win_addr == PTR_OFF) begin
            sel = SEL_PTR;
        end else if (win_addr == PORT_OFF) begin
            sel = SEL_PORT;
        end
    end

endmodule

// File: rtl/ixw_ptr_reg.sv
module ixw_ptr_reg #(
    parameter int IADDR_W = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IADDR_W-1:2] wr_word,
    output logic [IADDR_W-1:0] ptr_q
);

    logic [IADDR_W-1:2] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_word;
        end
    end

    assign ptr_q = {word_q, 2'b00};

endmodule

// File: rtl/ixw_seq.sv
module ixw_seq
    import ixw_pkg::*;
#(
    parameter int                 IADDR_W  = 19,
    parameter logic [IADDR_W-1:0] REG_BASE = 19'h50000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_we,
    input  win_sel_t           sel,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic [IADDR_W-1:0] ptr,
    output logic               ptr_wr_en,
    output logic               host_ack,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               ib_req,
    output logic               ib_we,
    output logic [IADDR_W-1:0] ib_addr,
    output logic [DATA_W-1:0]  ib_wdata,
    input  logic [DATA_W-1:0]  ib_rdata,
    input  logic               ib_ready
);

    localparam int PAD_W = DATA_W - IADDR_W;

    seq_state_t state_q;

    assign ptr_wr_en = (state_q == ST_IDLE) && host_req && host_we && (sel == SEL_PTR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            host_ack   <= 1'b0;
            host_rdata <= '0;
            ib_req     <= 1'b0;
            ib_we      <= 1'b0;
            ib_addr    <= '0;
            ib_wdata   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (host_req) begin
                        case (sel)
                            SEL_PORT: begin
                                ib_req   <= 1'b1;
                                ib_we    <= host_we;
                                ib_addr  <= ptr + REG_BASE;
                                ib_wdata <= host_wdata;
                                state_q  <= ST_WAIT;
                            end
                            SEL_PTR: begin
                                host_ack <= 1'b1;
                                if (!host_we) host_rdata <= {{PAD_W{1'b0}}, ptr};
                                state_q  <= ST_DONE;
                            end
                            default: begin
                                host_ack <= 1'b1;
                                if (!host_we) host_rdata <= '0;
                                state_q  <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (ib_ready) begin
                        ib_req   <= 1'b0;
                        host_ack <= 1'b1;
                        if (!ib_we) host_rdata <= ib_rdata;
                        state_q  <= ST_DONE;
                    end
                end
                default: begin
                    host_ack <= 1'b0;
                    state_q  <= ST_IDLE;
                end
            endcase
        end
    end

    // R5
    ib_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ready) |=> (ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    // R4
    ack_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ready) |=> (host_ack && !ib_req));

    // R4
    no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ib_req |-> !host_ack);

endmodule

// File: rtl/ind_window_bridge.sv
module ind_window_bridge
    import ixw_pkg::*;
#(
    parameter int                 WIN_AW   = 8,
    parameter int                 IADDR_W  = 19,
    parameter logic [WIN_AW-1:0]  PTR_OFF  = 8'h40,
    parameter logic [WIN_AW-1:0]  PORT_OFF = 8'h44,
    parameter logic [IADDR_W-1:0] REG_BASE = 19'h50000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [WIN_AW-1:0]  host_addr,
    input  logic [31:0]        host_wdata,
    output logic               host_ack,
    output logic [31:0]        host_rdata,
    output logic               ib_req,
    output logic               ib_we,
    output logic [IADDR_W-1:0] ib_addr,
    output logic [31:0]        ib_wdata,
    input  logic [31:0]        ib_rdata,
    input  logic               ib_ready
);

    win_sel_t           sel;
    logic               ptr_wr_en;
    logic [IADDR_W-1:0] ptr;

    ixw_decode #(
        .WIN_AW  (WIN_AW),
        .PTR_OFF (PTR_OFF),
        .PORT_OFF(PORT_OFF)
    ) u_decode (
        .win_addr(host_addr),
        .sel     (sel)
    );

    ixw_ptr_reg #(
        .IADDR_W(IADDR_W)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ptr_wr_en),
        .wr_word(host_wdata[IADDR_W-1:2]),
        .ptr_q  (ptr)
    );

    ixw_seq #(
        .IADDR_W (IADDR_W),
        .REG_BASE(REG_BASE)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .host_req  (host_req),
        .host_we   (host_we),
        .sel       (sel),
        .host_wdata(host_wdata),
        .ptr       (ptr),
        .ptr_wr_en (ptr_wr_en),
        .host_ack  (host_ack),
        .host_rdata(host_rdata),
        .ib_req    (ib_req),
        .ib_we     (ib_we),
        .ib_addr   (ib_addr),
        .ib_wdata  (ib_wdata),
        .ib_rdata  (ib_rdata),
        .ib_ready  (ib_ready)
    );

endmodule

// File: tb/ind_window_bridge_bench.sv
module ind_window_bridge_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [18:0] BENCH_BASE = 19'h50000;
    localparam logic [7:0]  OFF_PTR    = 8'h40;
    localparam logic [7:0]  OFF_PORT   = 8'h44;
    localparam int          NVEC       = 6;

    localparam logic [31:0] VEC_PTR  [NVEC] = '{32'h0000_0000, 32'h0000_1237, 32'h0007_FFFC,
                                                 32'h0012_3458, 32'h0003_0000, 32'hFFFF_FFFF};
    localparam logic [31:0] VEC_DATA [NVEC] = '{32'hDEAD_BEEF, 32'h0000_0000, 32'h1234_5678,
                                                 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0BAD_F00D};
    localparam int          VEC_DLY  [NVEC] = '{0, 1, 3, 0, 4, 2};
    localparam bit          VEC_WR   [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic        ib_req;
    logic        ib_we;
    logic [18:0] ib_addr;
    logic [31:0] ib_wdata;
    logic [31:0] ib_rdata = '0;
    logic        ib_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int          cur_dly = 0;
    int          wait_cnt = 0;
    int          txn_cnt = 0;
    int          stable_err = 0;
    logic [18:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic [31:0] last_wdata = '0;
    logic [18:0] first_addr = '0;
    logic [31:0] first_wdata = '0;

    ind_window_bridge #(.REG_BASE(BENCH_BASE)) u_ind_window_bridge (
        .clk       (clk),
        .rst       (rst),
        .host_req  (host_req),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_ack  (host_ack),
        .host_rdata(host_rdata),
        .ib_req    (ib_req),
        .ib_we     (ib_we),
        .ib_addr   (ib_addr),
        .ib_wdata  (ib_wdata),
        .ib_rdata  (ib_rdata),
        .ib_ready  (ib_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [18:0] exp_ib(input logic [31:0] p);
        logic [18:0] w;
        w = p[18:0] & 19'h7FFFC;
        return w + BENCH_BASE;
    endfunction

    function automatic logic [31:0] resp_val(input logic [18:0] a);
        return {13'h0, a} ^ 32'hC3C0_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Internal bus responder
    initial begin
        forever begin
            @(negedge clk);
            if (ib_req && !ib_ready) begin
                if (wait_cnt == 0) begin
                    first_addr  = ib_addr;
                    first_wdata = ib_wdata;
                end else if (ib_addr != first_addr || ib_wdata != first_wdata) begin
                    stable_err++;
                end
                if (wait_cnt >= cur_dly) begin
                    ib_ready   = 1'b1;
                    ib_rdata   = resp_val(ib_addr);
                    last_addr  = ib_addr;
                    last_we    = ib_we;
                    last_wdata = ib_wdata;
                    txn_cnt++;
                    wait_cnt   = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                ib_ready = 1'b0;
                wait_cnt = 0;
            end
        end
    end

    task automatic host_op(input logic we, input logic [7:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = a;
        host_wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!host_ack && cyc < 50);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          cyc;
        int          t0;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(host_ack == 1'b0, "R1", "ack in reset", {31'b0, host_ack}, 32'd0);
        chk(ib_req == 1'b0, "R1", "ib_req in reset", {31'b0, ib_req}, 32'd0);
        rst = 1'b0;
        host_op(1'b0, OFF_PTR, 32'h0, rd, cyc);
        chk(rd == 32'h0, "R1", "pointer after reset", rd, 32'h0);
        chk(cyc == 1, "R2", "pointer access latency", cyc, 1);

        // Vector table: R2, R3, R4, R9
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] exp_ptr;
            logic [18:0] ea;
            exp_ptr = {13'h0, VEC_PTR[i][18:2], 2'b00};
            ea = exp_ib(VEC_PTR[i]);
            host_op(1'b1, OFF_PTR, VEC_PTR[i], rd, cyc);
            host_op(1'b0, OFF_PTR, 32'h0, rd, cyc);
            chk(rd == exp_ptr, "R2", "pointer readback", rd, exp_ptr);
            t0 = txn_cnt;
            cur_dly = VEC_DLY[i];
            host_op(VEC_WR[i], OFF_PORT, VEC_DATA[i], rd, cyc);
            chk(txn_cnt == t0 + 1, "R3", "one internal access", txn_cnt - t0, 1);
            chk(last_addr == ea, "R9", "internal address with base", {13'h0, last_addr}, {13'h0, ea});
            chk(last_we == VEC_WR[i], "R3", "internal direction", {31'b0, last_we}, {31'b0, VEC_WR[i]});
            if (VEC_WR[i]) begin
                chk(last_wdata == VEC_DATA[i], "R3", "internal write data", last_wdata, VEC_DATA[i]);
            end else begin
                chk(rd == resp_val(ea), "R4", "read data returned", rd, resp_val(ea));
            end
            chk(cyc == 2 + VEC_DLY[i], "R4", "data port stall", cyc, 2 + VEC_DLY[i]);
        end

        // R6 acknowledge is a single pulse
        cur_dly = 2;
        host_op(1'b0, OFF_PORT, 32'h0, rd, cyc);
        @(negedge clk);
        chk(host_ack == 1'b0, "R6", "ack drops after one cycle", {31'b0, host_ack}, 32'd0);

        // R5 request held stable during waits
        cur_dly = 4;
        host_op(1'b1, OFF_PORT, 32'h7777_1111, rd, cyc);
        chk(stable_err == 0, "R5", "internal request stable while waiting", stable_err, 0);

        // R7 pointer rewrite redirects; pointer persists
        cur_dly = 0;
        host_op(1'b1, OFF_PTR, 32'h0000_2000, rd, cyc);
        host_op(1'b1, OFF_PTR, 32'h0000_4444, rd, cyc);
        host_op(1'b1, OFF_PORT, 32'h0000_00AA, rd, cyc);
        chk(last_addr == exp_ib(32'h4444), "R7", "rewrite redirects", {13'h0, last_addr},
            {13'h0, exp_ib(32'h4444)});
        host_op(1'b0, OFF_PORT, 32'h0, rd, cyc);
        chk(last_addr == exp_ib(32'h4444), "R7", "pointer persists", {13'h0, last_addr},
            {13'h0, exp_ib(32'h4444)});
        chk(rd == resp_val(exp_ib(32'h4444)), "R7", "repeat read data", rd, resp_val(exp_ib(32'h4444)));

        // R8 unmapped and misaligned offsets
        t0 = txn_cnt;
        host_op(1'b1, 8'h10, 32'hFFFF_FFFF, rd, cyc);
        chk(cyc == 1, "R8", "unmapped write latency", cyc, 1);
        host_op(1'b0, 8'h10, 32'h0, rd, cyc);
        chk(rd == 32'h0, "R8", "unmapped read value", rd, 32'h0);
        host_op(1'b1, 8'h42, 32'h0001_0000, rd, cyc);
        host_op(1'b0, 8'h46, 32'h0, rd, cyc);
        chk(rd == 32'h0, "R8", "misaligned read value", rd, 32'h0);
        chk(txn_cnt == t0, "R8", "no internal access", txn_cnt - t0, 0);
        host_op(1'b0, OFF_PTR, 32'h0, rd, cyc);
        chk(rd == 32'h0000_4444, "R8", "pointer untouched", rd, 32'h0000_4444);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule